// File: doc/BRIEF.md
# T1 Transmit Multiframe Overhead Generator

This block keeps the transmit timing of a T1 line. It counts the 193 bit times of each frame and the frames of each multiframe. In the first bit time of every frame it drives the framing overhead bit, which is placed ahead of the 24 channel bytes. One mode pin selects the multiframe type: a 12-frame superframe (D4) or a 24-frame extended superframe (ESF). Other logic uses the counters, a multiframe-start strobe and two markers for the frames that carry signaling bits. It uses them to place its own bits around the overhead slot.

The multiframe position can be set in three ways. Left alone, the counters free-run. An external pulse forces them back to the start of the multiframe on the next cycle, whatever the count was. A software request makes the block watch the overhead bits received on the incoming side. Once a full, correctly ordered multiframe pattern has been received, the block moves its own counters to the start of a multiframe. The request then clears itself.

All pins are plain control and status pins, and there is no back-pressure anywhere. The received-bit strobe is taken whenever it is high. Every clock is one line bit time.

Top module: `t1_ohgen`

## Requirements
- R1: `bit_cnt` steps by one each clock from 0 to 192 and then returns to 0. `frame_cnt` (0-based) steps at that return and wraps after index 11 when `esf_mode`=0, or after index 23 when `esf_mode`=1.
- R2: `oh_slot` is 1 exactly when `bit_cnt`=0. `oh_bit` carries the overhead bit in that cycle and is 0 in every other bit time.
- R3: With `esf_mode`=0, the overhead bit for frame index 0..11 is 1,0,0,0,1,1,0,1,1,1,0,0. Even indices carry the alternating 1,0,1,0,1,0 frame-alignment bits. Odd indices carry the superframe sequence 0,0,1,1,1,0.
- R4: With `esf_mode`=1, frame indices 3,7,11,15,19,23 carry 0,0,1,0,1,1. Every other frame index carries 0.
- R5: `mf_start` is 1 exactly when `frame_cnt`=0 and `bit_cnt`=0.
- R6: `sig_a_frame` is 1 for the whole frame when `frame_cnt` mod 12 = 5. `sig_b_frame` is 1 for the whole frame when `frame_cnt` mod 12 = 11.
- R7: `ext_mf_rst` high at a clock edge makes both counters 0 in the next cycle, from any count.
- R8: `sw_sync_req` high at an edge sets `sync_busy` in the next cycle. Each cycle with `rx_oh_valid`=1 shifts `rx_oh_bit` into a history. At least a multiframe length (12 or 24) of bits must have been received since the request. When the newest bits then equal the R3/R4 pattern for frame indices 0 through last, with the newest bit as the last frame, both counters are 0 and `sync_busy` is 0 in the next cycle.
- R9: A pattern match found before a full multiframe length of bits has arrived since the request causes no alignment. `sync_busy` stays 1 and the counters keep running.
- R10: `ext_mf_rst` has priority over software sync. It cancels a pending request, and it cancels a request or a match in the same cycle. `sync_busy` is 0 in the next cycle, and that request never aligns the counters later.
- R11: While `rst_n`=0: `bit_cnt`=0, `frame_cnt`=0 and `sync_busy`=0, so `mf_start` and `oh_slot` read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| esf_mode | input | 1 | 0 = 12-frame D4, 1 = 24-frame ESF |
| ext_mf_rst | input | 1 | External multiframe reset pulse |
| sw_sync_req | input | 1 | Software request to align to the received pattern |
| rx_oh_valid | input | 1 | Strobe: a received overhead bit is present |
| rx_oh_bit | input | 1 | Received overhead bit |
| oh_bit | output | 1 | Serialized transmit overhead bit |
| oh_slot | output | 1 | Current bit time is the overhead position |
| bit_cnt | output | 8 | Bit index within the frame (0..192) |
| frame_cnt | output | 5 | Frame index within the multiframe (0-based) |
| mf_start | output | 1 | First bit of the multiframe |
| sig_a_frame | output | 1 | Frame carries A signaling bits |
| sig_b_frame | output | 1 | Frame carries B signaling bits |
| sync_busy | output | 1 | Software sync request pending |

## Verification
Two functions can land in the same cycle: an external multiframe reset, and a software sync, either as a new request or as the final matching bit of a pending one. The bench causes both collisions. It raises the reset pin and the request together. It also raises the reset pin in the same cycle as the strobe that carries the last bit of a full received pattern. Each result passes only if `sync_busy` is low and the counters are at zero in the next cycle. A further complete pattern is then fed in, and the counters must keep the phase counted from that reset, which shows the cancelled request did not realign them later.

// File: rtl/t1oh_pkg.sv
`timescale 1ns/1ps
package t1oh_pkg;
  localparam int unsigned MAX_MF     = 24;
  localparam int unsigned D4_LEN     = 12;
  localparam int unsigned MF_W       = $clog2(MAX_MF);
  localparam int unsigned SIG_PERIOD = 12;
  localparam int unsigned SIG_A_IDX  = 5;
  localparam int unsigned SIG_B_IDX  = 11;
  // bit k = k-th element of the sequence
  localparam logic [5:0] FS_SEQ  = 6'b011100;
  localparam logic [5:0] FPS_SEQ = 6'b110100;

  function automatic logic oh_expected(input logic esf, input int unsigned fidx);
    logic [2:0]  k;
    int unsigned f;
    if (esf) begin
      k = 3'(fidx / 4);
      return (fidx % 4 == 3) ? FPS_SEQ[k] : 1'b0;
    end
    f = fidx % D4_LEN;
    k = 3'(f / 2);
    return (f % 2 == 0) ? ~k[0] : FS_SEQ[k];
  endfunction

  // Oldest frame in the high bit, last frame of the multiframe in bit 0.
  function automatic logic [MAX_MF-1:0] mf_window(input logic esf);
    logic [MAX_MF-1:0] w;
    logic [MF_W-1:0]   pos;
    int unsigned       len;
    w   = '0;
    len = esf ? MAX_MF : D4_LEN;
    for (int unsigned i = 0; i < MAX_MF; i++) begin
      if (i < len) begin
        pos    = MF_W'(len - 1 - i);
        w[pos] = oh_expected(esf, i);
      end
    end
    return w;
  endfunction
endpackage

// File: rtl/t1oh_counter.sv
`timescale 1ns/1ps
module t1oh_counter
  import t1oh_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 193,
  localparam int unsigned BW = $clog2(FRAME_BITS),
  localparam int unsigned FW = $clog2(MAX_MF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          esf_mode,
  input  logic          load,
  output logic [BW-1:0] bit_cnt,
  output logic [FW-1:0] frame_cnt
);
  logic [BW-1:0] bit_q;
  logic [FW-1:0] frame_q;
  logic [FW-1:0] last_frame;

  assign last_frame = esf_mode ? FW'(MAX_MF - 1) : FW'(D4_LEN - 1);

  always_ff @(posedge clk) begin
    if (!rst_n || load) begin
      bit_q   <= '0;
      frame_q <= '0;
    end else if (bit_q == BW'(FRAME_BITS - 1)) begin
      bit_q   <= '0;
      frame_q <= (frame_q >= last_frame) ? '0 : frame_q + 1'b1;
    end else begin
      bit_q <= bit_q + 1'b1;
    end
  end

  assign bit_cnt   = bit_q;
  assign frame_cnt = frame_q;
endmodule

// File: rtl/t1oh_marker.sv
`timescale 1ns/1ps
module t1oh_marker
  import t1oh_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 193,
  localparam int unsigned BW = $clog2(FRAME_BITS),
  localparam int unsigned FW = $clog2(MAX_MF)
) (
  input  logic          esf_mode,
  input  logic [BW-1:0] bit_cnt,
  input  logic [FW-1:0] frame_cnt,
  output logic          oh_bit,
  output logic          oh_slot,
  output logic          mf_start,
  output logic          sig_a_frame,
  output logic          sig_b_frame
);
  logic [FW-1:0] fmod;

  assign oh_slot  = (bit_cnt == '0);
  assign oh_bit   = oh_slot & oh_expected(esf_mode, 32'(frame_cnt));
  assign mf_start = oh_slot & (frame_cnt == '0);

  assign fmod = (frame_cnt >= FW'(SIG_PERIOD)) ? frame_cnt - FW'(SIG_PERIOD) : frame_cnt;
  assign sig_a_frame = (fmod == FW'(SIG_A_IDX));
  assign sig_b_frame = (fmod == FW'(SIG_B_IDX));
endmodule

// File: rtl/t1oh_align.sv
`timescale 1ns/1ps
module t1oh_align
  import t1oh_pkg::*;
#(
  localparam int unsigned CW = $clog2(MAX_MF + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic esf_mode,
  input  logic ext_mf_rst,
  input  logic sw_sync_req,
  input  logic rx_oh_valid,
  input  logic rx_oh_bit,
  output logic align,
  output logic sync_busy
);
  logic              busy_q;
  logic [MAX_MF-2:0] win_q;
  logic [MAX_MF-1:0] win_nx, want, mask;
  logic [CW-1:0]     seen_q, need;
  logic              hit;

  assign win_nx = {win_q, rx_oh_bit};
  assign want   = mf_window(esf_mode);
  assign mask   = esf_mode ? '1 : {{(MAX_MF - D4_LEN){1'b0}}, {D4_LEN{1'b1}}};
  assign need   = esf_mode ? CW'(MAX_MF - 1) : CW'(D4_LEN - 1);
  assign hit    = (((win_nx ^ want) & mask) == '0);
  assign align  = busy_q & rx_oh_valid & ~ext_mf_rst & ~sw_sync_req & (seen_q >= need) & hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      win_q  <= '0;
      seen_q <= '0;
    end else begin
      if (rx_oh_valid) win_q <= win_nx[MAX_MF-2:0];
      if (ext_mf_rst) begin
        busy_q <= 1'b0;
        seen_q <= '0;
      end else if (sw_sync_req) begin
        busy_q <= 1'b1;
        seen_q <= '0;
      end else begin
        if (align) busy_q <= 1'b0;
        if (busy_q && rx_oh_valid && seen_q < CW'(MAX_MF)) seen_q <= seen_q + 1'b1;
      end
    end
  end

  assign sync_busy = busy_q;
endmodule

// File: rtl/t1_ohgen.sv
`timescale 1ns/1ps
module t1_ohgen
  import t1oh_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 193,
  localparam int unsigned BW = $clog2(FRAME_BITS),
  localparam int unsigned FW = $clog2(MAX_MF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          esf_mode,
  input  logic          ext_mf_rst,
  input  logic          sw_sync_req,
  input  logic          rx_oh_valid,
  input  logic          rx_oh_bit,
  output logic          oh_bit,
  output logic          oh_slot,
  output logic [BW-1:0] bit_cnt,
  output logic [FW-1:0] frame_cnt,
  output logic          mf_start,
  output logic          sig_a_frame,
  output logic          sig_b_frame,
  output logic          sync_busy
);
  logic align;

  t1oh_align u_align (
    .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .ext_mf_rst(ext_mf_rst),
    .sw_sync_req(sw_sync_req), .rx_oh_valid(rx_oh_valid), .rx_oh_bit(rx_oh_bit),
    .align(align), .sync_busy(sync_busy)
  );

  t1oh_counter #(.FRAME_BITS(FRAME_BITS)) u_counter (
    .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .load(ext_mf_rst | align),
    .bit_cnt(bit_cnt), .frame_cnt(frame_cnt)
  );

  t1oh_marker #(.FRAME_BITS(FRAME_BITS)) u_marker (
    .esf_mode(esf_mode), .bit_cnt(bit_cnt), .frame_cnt(frame_cnt),
    .oh_bit(oh_bit), .oh_slot(oh_slot), .mf_start(mf_start),
    .sig_a_frame(sig_a_frame), .sig_b_frame(sig_b_frame)
  );
endmodule

// File: rtl/t1_ohgen_chk.sv
`timescale 1ns/1ps
module t1_ohgen_chk
#(
  parameter int unsigned FRAME_BITS = 193,
  localparam int unsigned BW = $clog2(FRAME_BITS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ext_mf_rst,
  input logic          rx_oh_valid,
  input logic          oh_bit,
  input logic          oh_slot,
  input logic [BW-1:0] bit_cnt,
  input logic [4:0]    frame_cnt,
  input logic          mf_start,
  input logic          sig_a_frame,
  input logic          sig_b_frame,
  input logic          sync_busy
);
  a_r1_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt < BW'(FRAME_BITS - 1) && !ext_mf_rst && !(sync_busy && rx_oh_valid))
    |=> (32'(bit_cnt) == 32'($past(bit_cnt)) + 1));

  a_r1_bit_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_cnt == BW'(FRAME_BITS - 1)) |=> (bit_cnt == '0));

  a_r2_oh_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    !oh_slot |-> !oh_bit);

  a_r5_mfs_slot: assert property (@(posedge clk) disable iff (!rst_n)
    mf_start |-> (oh_slot && frame_cnt == '0));

  a_r6_markers_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sig_a_frame, sig_b_frame}));

  a_r7_ext_load: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mf_rst |=> (bit_cnt == '0 && frame_cnt == '0));

  a_r8_sync_lands: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sync_busy) && !$past(ext_mf_rst)) |-> (bit_cnt == '0 && frame_cnt == '0));

  a_r10_ext_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mf_rst |=> !sync_busy);
endmodule

bind t1_ohgen t1_ohgen_chk #(.FRAME_BITS(FRAME_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_mf_rst(ext_mf_rst), .rx_oh_valid(rx_oh_valid),
  .oh_bit(oh_bit), .oh_slot(oh_slot), .bit_cnt(bit_cnt), .frame_cnt(frame_cnt),
  .mf_start(mf_start), .sig_a_frame(sig_a_frame), .sig_b_frame(sig_b_frame),
  .sync_busy(sync_busy)
);

// File: tb/t1_ohgen_bench.sv
`timescale 1ns/1ps
module t1_ohgen_bench;
  localparam int FB = 193;
  localparam logic [0:11] D4_SEQ  = 12'b1000_1101_1100;
  localparam logic [0:23] ESF_SEQ = 24'b0000_0000_0001_0000_0001_0001;
  // {esf, frame, oh, sigA, sigB}
  localparam logic [8:0] VECS [36] = '{
    {1'b0,5'd0,3'b100}, {1'b0,5'd1,3'b000}, {1'b0,5'd2,3'b000}, {1'b0,5'd3,3'b000},
    {1'b0,5'd4,3'b100}, {1'b0,5'd5,3'b110}, {1'b0,5'd6,3'b000}, {1'b0,5'd7,3'b100},
    {1'b0,5'd8,3'b100}, {1'b0,5'd9,3'b100}, {1'b0,5'd10,3'b000}, {1'b0,5'd11,3'b001},
    {1'b1,5'd0,3'b000}, {1'b1,5'd1,3'b000}, {1'b1,5'd2,3'b000}, {1'b1,5'd3,3'b000},
    {1'b1,5'd4,3'b000}, {1'b1,5'd5,3'b010}, {1'b1,5'd6,3'b000}, {1'b1,5'd7,3'b000},
    {1'b1,5'd8,3'b000}, {1'b1,5'd9,3'b000}, {1'b1,5'd10,3'b000}, {1'b1,5'd11,3'b101},
    {1'b1,5'd12,3'b000}, {1'b1,5'd13,3'b000}, {1'b1,5'd14,3'b000}, {1'b1,5'd15,3'b000},
    {1'b1,5'd16,3'b000}, {1'b1,5'd17,3'b010}, {1'b1,5'd18,3'b000}, {1'b1,5'd19,3'b100},
    {1'b1,5'd20,3'b000}, {1'b1,5'd21,3'b000}, {1'b1,5'd22,3'b000}, {1'b1,5'd23,3'b101}
  };

  logic clk = 0, rst_n = 0, esf_mode = 0, ext_mf_rst = 0, sw_sync_req = 0;
  logic rx_oh_valid = 0, rx_oh_bit = 0;
  logic oh_bit, oh_slot, mf_start, sig_a_frame, sig_b_frame, sync_busy;
  logic [7:0] bit_cnt;
  logic [4:0] frame_cnt;
  int errors = 0, checks = 0, cyc = 0, load_ref = 0;

  t1_ohgen u_t1_ohgen (
    .clk(clk), .rst_n(rst_n), .esf_mode(esf_mode), .ext_mf_rst(ext_mf_rst),
    .sw_sync_req(sw_sync_req), .rx_oh_valid(rx_oh_valid), .rx_oh_bit(rx_oh_bit),
    .oh_bit(oh_bit), .oh_slot(oh_slot), .bit_cnt(bit_cnt), .frame_cnt(frame_cnt),
    .mf_start(mf_start), .sig_a_frame(sig_a_frame), .sig_b_frame(sig_b_frame),
    .sync_busy(sync_busy)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_mf_rst = 1; load_ref = cyc + 1;
    @(negedge clk); ext_mf_rst = 0;
  endtask

  task automatic req_sync();
    @(negedge clk); sw_sync_req = 1;
    @(negedge clk); sw_sync_req = 0;
  endtask

  task automatic feed(input logic b);
    @(negedge clk); rx_oh_valid = 1; rx_oh_bit = b;
    @(negedge clk); rx_oh_valid = 0;
  endtask

  task automatic check_phase(input string req, input int len);
    int n;
    n = cyc - load_ref;
    check({req, " bit phase"}, int'(bit_cnt), n % FB);
    check({req, " frame phase"}, int'(frame_cnt), (n / FB) % len);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic e, o, a, b;
    logic [4:0] f;
    // R11 reset state
    repeat (3) @(negedge clk);
    check("R11 bit_cnt", int'(bit_cnt), 0);
    check("R11 frame_cnt", int'(frame_cnt), 0);
    check("R11 mf_start", int'(mf_start), 1);
    check("R11 sync_busy", int'(sync_busy), 0);
    rst_n = 1;

    // Table walk: R3 R4 R2 R5 R6
    for (int v = 0; v < 36; v++) begin
      {e, f, o, a, b} = VECS[v];
      @(negedge clk); esf_mode = e;
      ext_pulse();
      repeat (int'(f) * FB) @(negedge clk);
      check(e ? "R4 oh_bit" : "R3 oh_bit", int'(oh_bit), int'(o));
      check("R2 oh_slot", int'(oh_slot), 1);
      check("R5 mf_start", int'(mf_start), (f == 0) ? 1 : 0);
      check("R6 sig_a", int'(sig_a_frame), int'(a));
      check("R6 sig_b", int'(sig_b_frame), int'(b));
      repeat (100) @(negedge clk);
      check("R2 oh_bit off-slot", int'(oh_bit), 0);
      check("R6 sig_a mid-frame", int'(sig_a_frame), int'(a));
      check("R6 sig_b mid-frame", int'(sig_b_frame), int'(b));
    end

    // R1 wrap, D4 then ESF
    @(negedge clk); esf_mode = 0;
    ext_pulse();
    repeat (12 * FB - 1) @(negedge clk);
    check("R1 d4 last frame", int'(frame_cnt), 11);
    check("R1 d4 last bit", int'(bit_cnt), 192);
    @(negedge clk);
    check("R1 d4 wrap frame", int'(frame_cnt), 0);
    check("R1 d4 wrap bit", int'(bit_cnt), 0);
    @(negedge clk); esf_mode = 1;
    ext_pulse();
    repeat (12 * FB) @(negedge clk);
    check("R1 esf frame 12", int'(frame_cnt), 12);
    repeat (12 * FB) @(negedge clk);
    check("R1 esf wrap", int'(frame_cnt), 0);

    // R7 external reset mid-count
    @(negedge clk); esf_mode = 0;
    ext_pulse();
    repeat (1000) @(negedge clk);
    check_phase("R1 free-run", 12);
    ext_pulse();
    check("R7 bit", int'(bit_cnt), 0);
    check("R7 frame", int'(frame_cnt), 0);

    // R9 early match blocked, then R8 D4 alignment
    ext_pulse();
    for (int i = 0; i < 11; i++) feed(D4_SEQ[i]);
    req_sync();
    check("R8 busy set", int'(sync_busy), 1);
    feed(D4_SEQ[11]);
    check("R9 still busy", int'(sync_busy), 1);
    check_phase("R9 no realign", 12);
    for (int i = 0; i < 11; i++) feed(D4_SEQ[i]);
    check("R8 busy before last", int'(sync_busy), 1);
    feed(D4_SEQ[11]);
    check("R8 d4 bit", int'(bit_cnt), 0);
    check("R8 d4 frame", int'(frame_cnt), 0);
    check("R8 d4 busy clear", int'(sync_busy), 0);

    // R8 ESF alignment with a late start phase
    @(negedge clk); esf_mode = 1;
    ext_pulse();
    repeat (700) @(negedge clk);
    req_sync();
    for (int i = 0; i < 23; i++) feed(ESF_SEQ[i]);
    check("R8 esf busy", int'(sync_busy), 1);
    feed(ESF_SEQ[23]);
    check("R8 esf bit", int'(bit_cnt), 0);
    check("R8 esf frame", int'(frame_cnt), 0);
    check("R8 esf mf_start", int'(mf_start), 1);
    check("R8 esf busy clear", int'(sync_busy), 0);

    // R10 reset and request in the same cycle
    @(negedge clk); esf_mode = 0;
    @(negedge clk); ext_mf_rst = 1; sw_sync_req = 1; load_ref = cyc + 1;
    @(negedge clk); ext_mf_rst = 0; sw_sync_req = 0;
    check("R10 same-cycle busy", int'(sync_busy), 0);
    check("R10 same-cycle bit", int'(bit_cnt), 0);
    for (int i = 0; i < 12; i++) feed(D4_SEQ[i]);
    check_phase("R10 request dropped", 12);

    // R10 reset in the cycle of the completing bit
    req_sync();
    for (int i = 0; i < 11; i++) feed(D4_SEQ[i]);
    @(negedge clk); rx_oh_valid = 1; rx_oh_bit = D4_SEQ[11]; ext_mf_rst = 1; load_ref = cyc + 1;
    @(negedge clk); rx_oh_valid = 0; ext_mf_rst = 0;
    check("R10 collide busy", int'(sync_busy), 0);
    check("R10 collide frame", int'(frame_cnt), 0);
    repeat (300) @(negedge clk);
    for (int i = 0; i < 12; i++) feed(D4_SEQ[i]);
    check_phase("R10 cancelled no align", 12);
    check("R10 busy stays low", int'(sync_busy), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule